// File: doc/BRIEF.md
# Processor Activity Watchdog Timer

This block supervises a processor by watching a heartbeat line that the software is expected to toggle. If the line is driven and stays at one level for longer than a programmable number of clock cycles, the active-low fault output is pulled low. This output would normally feed the processor's non-maskable interrupt. Both rising and falling transitions count as signs of life.

The heartbeat line has three states: high, low and undriven. Since the undriven state cannot be sensed in logic, a separate "driven" flag comes with the level. While the line is undriven, the timer is held cleared. The timer is also held cleared while the system reset from the reset generator is asserted. An undervoltage flag forces the fault output low at any time. When the heartbeat is left undriven for good, the block therefore acts as a plain low-supply indicator.

The heartbeat level and the driven flag each pass through a two-flop synchronizer and one edge-detect register before they reach the timer. The timeout parameter defaults to 1.6 s at 50 MHz.

Top module: `activity_watchdog`

## Requirements
- R1: While `rst_n` is low and for the cycle after it is released, `wdog_fault_n` is high, provided `undervolt` is low.
- R2: With `hb_driven` high, `sys_reset` low and `hb_level` held steady after a change, `wdog_fault_n` is still high after clock edge TIMEOUT+2 and goes low on edge TIMEOUT+3, counting the first edge after the change as edge 1.
- R3: A rising transition and a falling transition of `hb_level` each restart the count from zero. Transitions spaced closer than TIMEOUT cycles keep `wdog_fault_n` high.
- R4: While `hb_driven` is low, the count stays at zero and the timer never expires. After `hb_driven` rises with a steady level, `wdog_fault_n` falls on edge TIMEOUT+3.
- R5: While `sys_reset` is high, the count stays at zero. After it falls with the heartbeat driven and steady, `wdog_fault_n` is high after edge TIMEOUT-1 and low after edge TIMEOUT.
- R6: When `undervolt` is high, `wdog_fault_n` is low without waiting for a clock edge, whatever the timer state. When it drops, the output returns to the timer's state, and the count in progress is not disturbed.
- R7: Once the fault is raised, it stays low until one of three events. A heartbeat transition releases it after edge 3. `hb_driven` falling releases it after edge 4. `sys_reset` rising releases it after edge 1.
- R8: With `hb_driven` held low, `wdog_fault_n` stays high for any length of time and goes low only while `undervolt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_level | input | 1 | Heartbeat level from the processor |
| hb_driven | input | 1 | High when the heartbeat line is actively driven |
| sys_reset | input | 1 | Active-high system reset from the reset generator |
| undervolt | input | 1 | High when the supply is below the reset threshold |
| wdog_fault_n | output | 1 | Active-low watchdog fault |

## Verification
The bench checks the exact expiry cycle after each kind of arming event: a level change, the driven flag rising, and system reset falling. A design with a missing or extra pipeline stage, or an off-by-one limit, fails on the cycle just before or just after expiry. Heartbeat transitions of both polarities are applied at intervals shorter than the timeout, so a design that restarts on only one edge direction faults partway through. Each of the three release paths is exercised against a latched fault, so a fault that clears by itself or fails to clear is reported. Undervoltage is asserted during an active count and then removed, which exposes an output that is only registered or a count that is disturbed.

// File: rtl/wdog_pkg.sv
// Shared types and helpers for the activity watchdog.
// Assumes TIMEOUT values of at least 2 cycles.
package wdog_pkg;

    // Heartbeat state as seen by the timer after synchronization
    typedef struct packed {
        logic driven;     // line is driven (delayed to align with edge_seen)
        logic edge_seen;  // a transition of the synchronized level
    } hb_status_t;

    // Counter width able to hold TIMEOUT-1, never below 1
    function automatic int unsigned cnt_width(input int unsigned limit);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) < 64'(limit)) w++;
        return w;
    endfunction

endpackage

// File: rtl/wdog_sync.sv
// Multi-bit chain of flops that brings asynchronous inputs into the clock domain.
// Each bit is synchronized independently; the bits are not assumed to be related.
module wdog_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= din;
                end
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/wdog_edge.sv
// Detects both transition directions on the synchronized heartbeat level and
// delays the driven flag by one cycle so both reach the timer in step.
// Assumes both inputs come from the same synchronizer.
module wdog_edge
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_sync,
    input  logic       drv_sync,
    output hb_status_t status
);
    logic lvl_q;
    logic drv_q;

    // Hold the previous level and the aligned driven flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            drv_q <= 1'b0;
        end else begin
            lvl_q <= lvl_sync;
            drv_q <= drv_sync;
        end
    end

    // Any difference between current and previous level is an edge
    always_comb begin
        status.driven    = drv_q;
        status.edge_seen = lvl_sync ^ lvl_q;
    end
endmodule

// File: rtl/wdog_timer.sv
// Timeout counter. It clears on system reset, on an undriven heartbeat or on a
// heartbeat edge. Otherwise it counts to TIMEOUT and then latches the expired
// flag until one of the clear conditions occurs.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT = 80_000_000,
    parameter int unsigned CW      = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_reset,
    input  hb_status_t    status,
    output logic [CW-1:0] count,
    output logic          expired
);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic clear;

    // Conditions that hold the timer at zero
    always_comb clear = sys_reset | ~status.driven | status.edge_seen;

    // Count up while armed; freeze and flag on reaching the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count   <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            if (count == LAST) expired <= 1'b1;
            else               count   <= count + 1'b1;
        end
    end
endmodule

// File: rtl/activity_watchdog.sv
// Processor activity watchdog. The heartbeat level and driven flag are
// synchronized, checked for edges in both directions, and fed to a timeout
// counter. The fault output is low on timeout or undervoltage.
// Assumes sys_reset and undervolt are already synchronous to clk.
module activity_watchdog
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT     = 80_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_level,
    input  logic hb_driven,
    input  logic sys_reset,
    input  logic undervolt,
    output logic wdog_fault_n
);
    localparam int unsigned CNT_W = cnt_width(TIMEOUT);

    logic [1:0]       sync_out;
    hb_status_t       hb_st;
    logic             hb_drv_q;
    logic             hb_edge;
    logic [CNT_W-1:0] tmr_count;
    logic             tmr_expired;

    wdog_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({hb_driven, hb_level}),
        .dout (sync_out)
    );

    wdog_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_sync(sync_out[0]),
        .drv_sync(sync_out[1]),
        .status  (hb_st)
    );

    wdog_timer #(.TIMEOUT(TIMEOUT), .CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_reset(sys_reset),
        .status   (hb_st),
        .count    (tmr_count),
        .expired  (tmr_expired)
    );

    // Unpack status for visibility to the checker
    always_comb begin
        hb_drv_q = hb_st.driven;
        hb_edge  = hb_st.edge_seen;
    end

    // Undervoltage overrides the timer without a clock edge
    always_comb wdog_fault_n = ~(tmr_expired | undervolt);
endmodule

// File: rtl/wdog_checker.sv
// Temporal checks on the watchdog, bound into every activity_watchdog instance.
module wdog_checker #(
    parameter int unsigned TIMEOUT = 80_000_000,
    parameter int unsigned CW      = 27
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_reset,
    input logic          undervolt,
    input logic          fault_n,
    input logic          hb_drv,
    input logic          hb_edge,
    input logic [CW-1:0] count,
    input logic          expired
);
    // R6: undervoltage forces the fault low
    p_uv_forces_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        undervolt |-> !fault_n);

    // R5: system reset holds the timer cleared
    p_sysrst_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> (count == '0 && !expired));

    // R4: undriven heartbeat holds the count at zero
    p_undriven_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_drv |=> (count == '0 && !expired));

    // R3: an edge in either direction restarts the count
    p_edge_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hb_edge |=> count == '0);

    // R7: a raised fault holds while no release event occurs
    p_fault_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && hb_drv && !hb_edge && !sys_reset) |=> expired);

    // R2: expiry only follows a full count
    p_no_early_expiry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(count) == CW'(TIMEOUT - 1));
endmodule

bind activity_watchdog wdog_checker #(.TIMEOUT(TIMEOUT), .CW(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_reset(sys_reset),
    .undervolt(undervolt),
    .fault_n  (wdog_fault_n),
    .hb_drv   (hb_drv_q),
    .hb_edge  (hb_edge),
    .count    (tmr_count),
    .expired  (tmr_expired)
);

// File: tb/sim_activity_watchdog.sv
// Scoreboard bench: the driver queues the expected fault level for future
// cycles, and the monitor compares at each falling clock edge.
module sim_activity_watchdog;
    localparam int TO = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb_level = 1'b0;
    logic hb_driven = 1'b0;
    logic sys_reset = 1'b0;
    logic undervolt = 1'b0;
    logic wdog_fault_n;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    activity_watchdog #(.TIMEOUT(TO)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hb_level    (hb_level),
        .hb_driven   (hb_driven),
        .sys_reset   (sys_reset),
        .undervolt   (undervolt),
        .wdog_fault_n(wdog_fault_n)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Count rising edges
    always @(posedge clk) cyc <= cyc + 1;

    // Queue one expected output value
    task automatic expect_at(input int at, input logic v, input string tag);
        exp_t e;
        e.at = at;
        e.val = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Move just past the next n falling edges
    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Wait until every queued expectation has been compared
    task automatic drain();
        while (q.size() > 0) step(1);
    endtask

    // Monitor: compare due items at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            n_chk++;
            if (q[0].at < cyc || wdog_fault_n !== q[0].val) begin
                n_fail++;
                $display("FAIL %s cycle %0d: fault_n=%0b expected %0b",
                         q[0].tag, cyc, wdog_fault_n, q[0].val);
            end
            void'(q.pop_front());
        end
    end

    // Driver
    initial begin
        int c, c2, c3, lastc;
        // R1: reset state
        step(2);
        c = cyc;
        expect_at(c + 1, 1'b1, "R1");
        step(2);
        rst_n = 1'b1;
        c = cyc;
        expect_at(c + 1, 1'b1, "R1");
        drain();

        // R8: undriven line never times out, undervoltage still reported
        c = cyc;
        expect_at(c + 5, 1'b1, "R8");
        expect_at(c + 2 * TO, 1'b1, "R8");
        drain();
        undervolt = 1'b1;
        c = cyc;
        expect_at(c + 1, 1'b0, "R8");
        step(3);
        undervolt = 1'b0;
        c = cyc;
        expect_at(c + 1, 1'b1, "R8");
        drain();

        // R4: driving the line arms the timer
        hb_driven = 1'b1;
        c = cyc;
        expect_at(c + TO + 2, 1'b1, "R4");
        expect_at(c + TO + 3, 1'b0, "R4");
        expect_at(c + TO + 12, 1'b0, "R7");
        drain();

        // R7 release by edge, then R2 expiry timing after a level change
        hb_level = 1'b1;
        c = cyc;
        expect_at(c + 2, 1'b0, "R7");
        expect_at(c + 3, 1'b1, "R7");
        expect_at(c + TO + 2, 1'b1, "R2");
        expect_at(c + TO + 3, 1'b0, "R2");
        drain();

        // R3: alternating edges keep the fault released
        lastc = 0;
        for (int i = 0; i < 6; i++) begin
            hb_level = ~hb_level;
            c = cyc;
            lastc = c;
            expect_at(c + 4, 1'b1, "R3");
            expect_at(c + 13, 1'b1, "R3");
            step(TO - 6);
        end
        expect_at(lastc + TO + 2, 1'b1, "R3");
        expect_at(lastc + TO + 3, 1'b0, "R3");
        drain();

        // R7 release by undriven line
        hb_driven = 1'b0;
        c = cyc;
        expect_at(c + 3, 1'b0, "R7");
        expect_at(c + 4, 1'b1, "R7");
        step(10);
        drain();
        hb_driven = 1'b1;
        c = cyc;
        expect_at(c + TO + 3, 1'b0, "R4");
        drain();

        // R7 release by system reset, R5 hold and restart timing
        sys_reset = 1'b1;
        c = cyc;
        expect_at(c + 1, 1'b1, "R7");
        expect_at(c + 2 * TO, 1'b1, "R5");
        drain();
        sys_reset = 1'b0;
        c = cyc;
        expect_at(c + TO - 1, 1'b1, "R5");
        expect_at(c + TO, 1'b0, "R5");
        drain();

        // R6: undervoltage mid-count, count undisturbed
        sys_reset = 1'b1;
        step(1);
        sys_reset = 1'b0;
        c = cyc;
        step(2);
        undervolt = 1'b1;
        c2 = cyc;
        expect_at(c2 + 1, 1'b0, "R6");
        step(3);
        undervolt = 1'b0;
        c3 = cyc;
        expect_at(c3 + 1, 1'b1, "R6");
        expect_at(c + TO - 1, 1'b1, "R6");
        expect_at(c + TO, 1'b0, "R6");
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog cycle %0d: fault_n=%0b expected run to end", cyc, wdog_fault_n);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule